// File: doc/BRIEF.md
# Supervisory Watchdog with Startup Window

This block watches a processor through a periodic kick strobe and asks for a system reset when the kicks stop. It counts only on a slow time-base tick supplied from outside. A normal timeout code sets the kick period. A separate startup code can open a longer first window after arming, so that a slow boot does not trigger a false reset. The first kick inside that window ends it, and normal timing applies from then on.

Two arming modes exist. In dependent mode the watchdog waits until power sequencing is finished and the system reset line has been released. In independent mode it ignores sequencing and arms once the supply is above undervoltage lockout and boot has finished. Every reset source returns the block to its disarmed state. The startup window is then applied again at the next arming. The reset sources are a software reboot, a manual reset, a rising edge of the enable input, a supply dip below lockout, and the watchdog's own expiry.

Top module: `supv_wdog`

## Requirements
- R1: With `mode_indep_i` = 0 (dependent), the block arms only while `seq_done_i` = 1 and `sys_rst_i` = 0. It disarms as soon as either condition is lost.
- R2: With `mode_indep_i` = 1 (independent), the block arms while `uvlo_ok_i` = 1 and `boot_done_i` = 1, whatever the value of `seq_done_i` or `sys_rst_i`.
- R3: A nonzero `start_code_i` value c (1 to 7) gives a first window of START_BASE << (c-1) ticks after arming. With no kick, `wd_rst_o` rises on the last tick of that window.
- R4: With `start_code_i` = 0 there is no startup window. The normal timeout of TO_BASE << `tmo_code_i` ticks applies from the moment of arming.
- R5: A kick reloads the normal timeout. A kick inside the startup window ends the window and starts the normal timeout. A kick wins over a tick that arrives in the same cycle.
- R6: On expiry, `wd_rst_o` is high for exactly one cycle and the block disarms. The expiry counts as a reset event. In independent mode the block arms again two cycles after the pulse.
- R7: A software reboot pulse, a manual reset pulse, a low-to-high edge on `enable_i`, or a fall of `uvlo_ok_i` disarms the block. The startup window is applied again in full at the next arming.
- R8: In dependent mode, after any reset event the block does not arm again until `seq_done_i` has been seen low and then high.
- R9: Only `tick_i` advances the counters. Kicks seen while the block is disarmed have no effect.
- R10: Both codes are captured when the block arms. Later changes to them take effect only at the next arming.
- R11: During and after reset, `wd_rst_o` is 0 and the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base tick |
| kick_i | input | 1 | Processor kick strobe |
| mode_indep_i | input | 1 | 0 = dependent arming, 1 = independent arming |
| seq_done_i | input | 1 | Power sequencing complete |
| sys_rst_i | input | 1 | System reset output is asserted |
| uvlo_ok_i | input | 1 | Supply is above undervoltage lockout |
| boot_done_i | input | 1 | Boot phase complete |
| sw_reboot_i | input | 1 | Software reboot pulse |
| man_rst_i | input | 1 | Manual reset pulse |
| enable_i | input | 1 | Enable level; a rising edge is a reset event |
| start_code_i | input | 3 | Startup window code, 0 = no window |
| tmo_code_i | input | 3 | Normal timeout code |
| wd_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that the reset-source inputs are single-cycle pulses or clean levels, and that the tick and kick inputs are synchronous strobes. They also assume that the configuration codes stay within three bits and are stable for the cycle in which arming happens. The stimulus changes every input only at the falling clock edge. It pulses kicks and reset sources for one cycle, and it changes the codes only while the block is disarmed, except in the test that checks that a change made while armed is ignored. The tick is either held high or held low for long stretches, so every expected expiry cycle can be worked out as a tick count from the arming edge.

// File: rtl/wdog_pkg.sv
// Shared types and code-to-tick mappings for the supervisory watchdog.
// Assumes codes are 3 bits; a base value is supplied by the caller.
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_START = 2'd1,
        WD_RUN   = 2'd2
    } wd_state_e;

    // Startup window length: code 0 means no window, 1..7 doubles per step.
    function automatic int unsigned start_ticks(input logic [2:0] code,
                                                input int unsigned base);
        if (code == 3'd0) return 0;
        return base << (int'(code) - 1);
    endfunction

    // Normal timeout length: doubles per code step starting at base.
    function automatic int unsigned tmo_ticks(input logic [2:0] code,
                                              input int unsigned base);
        return base << int'(code);
    endfunction

endpackage

// File: rtl/wdog_arm_ctrl.sv
// Arming qualifier and reset-event collector.
// Produces the level that allows the watchdog to run and a combined
// reset-event strobe. Assumes pulse inputs are synchronous to clk.
module wdog_arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_indep_i,
    input  logic seq_done_i,
    input  logic sys_rst_i,
    input  logic uvlo_ok_i,
    input  logic boot_done_i,
    input  logic sw_reboot_i,
    input  logic man_rst_i,
    input  logic enable_i,
    input  logic expiry_i,
    output logic arm_o,
    output logic evt_o
);

    logic en_q;
    logic uvlo_q;
    logic need_reseq;
    logic en_rise;
    logic uvlo_fall;

    // Remember previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b1;
            uvlo_q <= 1'b0;
        end else begin
            en_q   <= enable_i;
            uvlo_q <= uvlo_ok_i;
        end
    end

    // Detect the level-change reset causes.
    always_comb begin
        en_rise   = enable_i & ~en_q;
        uvlo_fall = uvlo_q & ~uvlo_ok_i;
    end

    // Merge all reset causes into one event strobe.
    always_comb begin
        evt_o = sw_reboot_i | man_rst_i | en_rise | uvlo_fall | expiry_i;
    end

    // Block dependent re-arming until sequencing is seen low again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_reseq <= 1'b0;
        end else if (evt_o) begin
            need_reseq <= 1'b1;
        end else if (!seq_done_i) begin
            need_reseq <= 1'b0;
        end
    end

    // Select the arming condition by mode.
    always_comb begin
        if (mode_indep_i) begin
            arm_o = uvlo_ok_i & boot_done_i;
        end else begin
            arm_o = seq_done_i & ~sys_rst_i & ~need_reseq;
        end
    end

    // R8
    evt_sets_reseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> need_reseq);

    // R8
    reseq_blocks_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (need_reseq && !mode_indep_i) |-> !arm_o);

endmodule

// File: rtl/wdog_timer.sv
// Watchdog state machine and down-counter.
// Captures both codes at arming, runs the startup window and then the
// normal timeout, and raises a one-cycle request on expiry. Assumes a
// reset event has priority over everything else in the same cycle.
module wdog_timer #(
    parameter int unsigned START_BASE = 4,
    parameter int unsigned TO_BASE    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic       arm_i,
    input  logic       evt_i,
    input  logic [2:0] start_code_i,
    input  logic [2:0] tmo_code_i,
    output logic       wd_rst_o
);
    import wdog_pkg::*;

    localparam int unsigned MAX_START = START_BASE << 6;
    localparam int unsigned MAX_TO    = TO_BASE << 7;
    localparam int unsigned MAX_LD    = (MAX_START > MAX_TO) ? MAX_START : MAX_TO;
    localparam int unsigned CNT_W     = $clog2(MAX_LD + 1);

    wd_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       tmo_lat;
    logic             wd_rst_q;
    logic [CNT_W-1:0] ld_start;
    logic [CNT_W-1:0] ld_tmo_new;
    logic [CNT_W-1:0] ld_tmo_lat;

    // Compute reload values from the codes.
    always_comb begin
        ld_start   = CNT_W'(start_ticks(start_code_i, START_BASE));
        ld_tmo_new = CNT_W'(tmo_ticks(tmo_code_i, TO_BASE));
        ld_tmo_lat = CNT_W'(tmo_ticks(tmo_lat, TO_BASE));
    end

    // Sequence arming, startup window, normal timeout and expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WD_IDLE;
            cnt      <= '0;
            tmo_lat  <= 3'd0;
            wd_rst_q <= 1'b0;
        end else begin
            wd_rst_q <= 1'b0;
            if (evt_i) begin
                state <= WD_IDLE;
            end else begin
                case (state)
                    WD_IDLE: begin
                        if (arm_i) begin
                            tmo_lat <= tmo_code_i;
                            if (start_code_i != 3'd0) begin
                                state <= WD_START;
                                cnt   <= ld_start;
                            end else begin
                                state <= WD_RUN;
                                cnt   <= ld_tmo_new;
                            end
                        end
                    end
                    WD_START, WD_RUN: begin
                        if (!arm_i) begin
                            state <= WD_IDLE;
                        end else if (kick_i) begin
                            state <= WD_RUN;
                            cnt   <= ld_tmo_lat;
                        end else if (tick_i) begin
                            if (cnt == CNT_W'(1)) begin
                                wd_rst_q <= 1'b1;
                                state    <= WD_IDLE;
                            end else begin
                                cnt <= cnt - CNT_W'(1);
                            end
                        end
                    end
                    default: state <= WD_IDLE;
                endcase
            end
        end
    end

    assign wd_rst_o = wd_rst_q;

    // R6
    rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |=> !wd_rst_o);

    // R6
    rst_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |-> (state == WD_IDLE));

    // R5
    kick_ends_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_START && arm_i && kick_i && !evt_i) |=> (state == WD_RUN));

    // R9
    idle_kick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_IDLE && !arm_i && kick_i) |=> (state == WD_IDLE && !wd_rst_o));

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WD_IDLE && arm_i && !evt_i && !tick_i && !kick_i) |=> $stable(cnt));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_LD));

endmodule

// File: rtl/supv_wdog.sv
// Supervisory watchdog top: joins the arming qualifier with the timer.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module supv_wdog #(
    parameter int unsigned START_BASE = 4,
    parameter int unsigned TO_BASE    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic       mode_indep_i,
    input  logic       seq_done_i,
    input  logic       sys_rst_i,
    input  logic       uvlo_ok_i,
    input  logic       boot_done_i,
    input  logic       sw_reboot_i,
    input  logic       man_rst_i,
    input  logic       enable_i,
    input  logic [2:0] start_code_i,
    input  logic [2:0] tmo_code_i,
    output logic       wd_rst_o
);

    logic arm;
    logic evt;
    logic wd_rst;

    wdog_arm_ctrl u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_indep_i (mode_indep_i),
        .seq_done_i   (seq_done_i),
        .sys_rst_i    (sys_rst_i),
        .uvlo_ok_i    (uvlo_ok_i),
        .boot_done_i  (boot_done_i),
        .sw_reboot_i  (sw_reboot_i),
        .man_rst_i    (man_rst_i),
        .enable_i     (enable_i),
        .expiry_i     (wd_rst),
        .arm_o        (arm),
        .evt_o        (evt)
    );

    wdog_timer #(
        .START_BASE (START_BASE),
        .TO_BASE    (TO_BASE)
    ) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .kick_i       (kick_i),
        .arm_i        (arm),
        .evt_i        (evt),
        .start_code_i (start_code_i),
        .tmo_code_i   (tmo_code_i),
        .wd_rst_o     (wd_rst)
    );

    assign wd_rst_o = wd_rst;

    // R7
    evt_then_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (man_rst_i || sw_reboot_i) |=> !wd_rst_o);

    // R1
    dep_needs_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_indep_i && (!seq_done_i || sys_rst_i)) |-> !arm);

endmodule

// File: tb/tb_supv_wdog.sv
module tb_supv_wdog;

    localparam int CLK_PERIOD = 10;
    localparam int SB = 4;
    localparam int TB = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick, kick, mode, seq, srst, uvlo, boot, swrb, mrst, en;
    logic [2:0] scode, tcode;
    logic       wd_rst;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supv_wdog #(.START_BASE(SB), .TO_BASE(TB)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .kick_i(kick),
        .mode_indep_i(mode), .seq_done_i(seq), .sys_rst_i(srst),
        .uvlo_ok_i(uvlo), .boot_done_i(boot), .sw_reboot_i(swrb),
        .man_rst_i(mrst), .enable_i(en), .start_code_i(scode),
        .tmo_code_i(tcode), .wd_rst_o(wd_rst)
    );

    // Vector: {mode, start code, timeout code}
    localparam logic [6:0] VEC [6] = '{
        {1'b0, 3'd0, 3'd0}, {1'b0, 3'd1, 3'd3}, {1'b1, 3'd0, 3'd5},
        {1'b1, 3'd3, 3'd0}, {1'b0, 3'd7, 3'd2}, {1'b1, 3'd0, 3'd7}
    };

    function automatic int exp_first(input logic [2:0] s, input logic [2:0] t);
        if (s != 3'd0) return SB << (int'(s) - 1);
        return TB << int'(t);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic do_reset(input logic m, input logic [2:0] s, input logic [2:0] t);
        @(negedge clk);
        rst_n = 1'b0; tick = 0; kick = 0; mode = m; seq = 0; srst = 1;
        uvlo = 1; boot = 0; swrb = 0; mrst = 0; en = 1; scode = s; tcode = t;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Make the arming condition true for the current mode (at a negedge).
    task automatic arm_now();
        if (mode) begin uvlo = 1; boot = 1; end
        else begin seq = 1; srst = 0; end
    endtask

    // Count negedges until wd_rst is seen; -1 if not within lim.
    task automatic count_rst(input int lim, output int n);
        bit found = 0;
        n = -1;
        for (int i = 1; i <= lim && !found; i++) begin
            @(negedge clk);
            if (wd_rst) begin n = i; found = 1; end
        end
    endtask

    // Watch for lim cycles and return 1 if wd_rst never rose.
    task automatic quiet(input int lim, output bit q);
        q = 1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (wd_rst) q = 0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog timeout");
        finish_run();
    end

    initial begin
        int n;
        bit q;
        rst_n = 0;

        // R11: reset state
        do_reset(0, 3'd0, 3'd0);
        check(wd_rst == 1'b0, "R11", wd_rst, 0);
        tick = 1;
        quiet(20, q);
        check(q, "R11 idle without arming", 0, 1);

        // R3 R4 R1 R2: table of modes and codes
        foreach (VEC[k]) begin
            do_reset(VEC[k][6], VEC[k][5:3], VEC[k][2:0]);
            tick = 1;
            arm_now();
            @(negedge clk);
            count_rst(400, n);
            check(n == exp_first(VEC[k][5:3], VEC[k][2:0]),
                  (VEC[k][5:3] != 0) ? "R3 window" : "R4 timeout",
                  n, exp_first(VEC[k][5:3], VEC[k][2:0]));
        end

        // R5: kick ends window, normal timeout from kick
        do_reset(1, 3'd2, 3'd1);
        tick = 1; arm_now();
        @(negedge clk);
        repeat (3) @(negedge clk);
        kick = 1; @(negedge clk); kick = 0;
        count_rst(100, n);
        check(n == 4, "R5 kick ends window", n, 4);

        // R5: periodic kicks keep it quiet
        do_reset(1, 3'd0, 3'd2);
        tick = 1; arm_now();
        q = 1;
        for (int j = 0; j < 10; j++) begin
            bit qq;
            quiet(5, qq);
            if (!qq) q = 0;
            kick = 1; @(negedge clk); kick = 0;
            if (wd_rst) q = 0;
        end
        check(q, "R5 kicks reload", 0, 1);

        // R6: one-cycle pulse, independent re-arm two cycles later
        do_reset(1, 3'd0, 3'd1);
        tick = 1; arm_now();
        @(negedge clk);
        count_rst(50, n);
        check(n == 4, "R6 first expiry", n, 4);
        @(negedge clk);
        check(wd_rst == 1'b0, "R6 pulse width", wd_rst, 0);
        count_rst(50, n);
        check(n == 5, "R6 re-arm after expiry", n + 1, 6);

        // R1 R8: dependent mode gating and re-sequencing
        do_reset(0, 3'd0, 3'd0);
        tick = 1; seq = 1; srst = 1;
        quiet(20, q);
        check(q, "R1 held by system reset", 0, 1);
        srst = 0;
        @(negedge clk);
        count_rst(50, n);
        check(n == 2, "R1 arms on release", n, 2);
        quiet(20, q);
        check(q, "R8 no re-arm without re-sequencing", 0, 1);
        seq = 0; @(negedge clk); seq = 1;
        @(negedge clk);
        count_rst(50, n);
        check(n == 2, "R8 re-arm after sequencing", n, 2);

        // R2: independent ignores sequencing
        do_reset(1, 3'd0, 3'd0);
        tick = 1; seq = 0; srst = 1; arm_now();
        @(negedge clk);
        count_rst(50, n);
        check(n == 2, "R2 independent arming", n, 2);

        // R9: no tick, no progress; kicks while armed without ticks harmless
        do_reset(1, 3'd0, 3'd0);
        tick = 0; arm_now();
        quiet(30, q);
        check(q, "R9 no tick no expiry", 0, 1);
        tick = 1;
        count_rst(50, n);
        check(n == 2, "R9 ticks resume", n, 2);

        // R9: kick while disarmed has no effect
        do_reset(0, 3'd1, 3'd3);
        tick = 1; seq = 1; srst = 1;
        kick = 1; @(negedge clk); kick = 0;
        srst = 0;
        @(negedge clk);
        count_rst(100, n);
        check(n == 4, "R9 idle kick ignored", n, 4);

        // R10: code change while armed is ignored
        do_reset(1, 3'd0, 3'd1);
        tick = 1; arm_now();
        @(negedge clk);
        tcode = 3'd7;
        @(negedge clk);
        kick = 1; @(negedge clk); kick = 0;
        count_rst(600, n);
        check(n == 4, "R10 latched timeout", n, 4);

        // R7: each reset source restarts the window
        for (int src = 0; src < 4; src++) begin
            do_reset(1, 3'd3, 3'd7);
            tick = 1; arm_now();
            @(negedge clk);
            repeat (2) @(negedge clk);
            case (src)
                0: begin mrst = 1; @(negedge clk); mrst = 0; end
                1: begin swrb = 1; @(negedge clk); swrb = 0; end
                2: begin en = 0; @(negedge clk); en = 1; @(negedge clk); end
                default: begin uvlo = 0; repeat (2) @(negedge clk); uvlo = 1; end
            endcase
            if (src == 3) begin
                @(negedge clk);
                count_rst(100, n);
                check(n == 16, "R7 supply dip", n, 16);
            end else begin
                count_rst(100, n);
                check(n == 17, "R7 reset source", n, 17);
            end
        end

        // R8: dependent mode after a manual reset
        do_reset(0, 3'd0, 3'd0);
        tick = 1; arm_now();
        mrst = 1; @(negedge clk); mrst = 0;
        quiet(20, q);
        check(q, "R8 blocked after manual reset", 0, 1);
        seq = 0; @(negedge clk); seq = 1;
        @(negedge clk);
        count_rst(50, n);
        check(n == 2, "R8 re-arm after manual reset", n, 2);

        finish_run();
    end

endmodule